// File: doc/BRIEF.md
# Pixel Bunch-Crossing Timestamp Buffer

This block is the digital tail of a single detector pixel. While a bunch train is running it watches a discriminator hit line and a bunch-crossing number broadcast to the whole array. Whenever the pixel fires in a new crossing, that crossing number goes into the next free slot of a small per-pixel store. Each recorded hit is therefore tied to exactly one crossing. Once the store is full, later hits are thrown away and a sticky overflow flag records the loss.

After the train ends, the gap before the next train is used to read the store. The pixel shows its oldest entry with a valid flag, along with the total hit count and the overflow flag. A readout acknowledge moves on to the next entry. When the last entry has been taken, or when a new train is announced, the slots, the count and the flag are all wiped.

Control is a three-state machine. IDLE waits for a train. CAPTURE records hits. DRAIN presents entries. The transitions are:
- `train_start` moves any state to CAPTURE and clears the store.
- `train_end` moves CAPTURE to DRAIN.
- Taking the last entry moves DRAIN to IDLE.
- An empty store in DRAIN moves to IDLE on the next cycle.

Top module: `pixel_tstamp_buf`

## Requirements
- R1: After reset the state is IDLE, `rd_valid` is 0, `rd_stamp` is 0, `hit_count` is 0 and `overflow` is 0.
- R2: In CAPTURE, a clock with `hit` high and a crossing number that differs from the last one seen stores `bunch_num` in the next free slot. `hit_count` rises by one after that edge.
- R3: When `hit` stays high over several clocks with the same `bunch_num`, only one entry is stored. A later change of `bunch_num` while `hit` is still high counts as a new crossing.
- R4: When `hit_count` equals DEPTH (default 4), a hit in a new crossing is discarded. The stored entries stay unchanged and `overflow` is set. `hit_count` never exceeds DEPTH.
- R5: In DRAIN with at least one entry, `rd_valid` is 1 and `rd_stamp` shows the oldest unread entry. Each clock with `rd_ack` high moves to the next entry in capture order. `hit_count` and `overflow` hold their train values until the store is cleared.
- R6: The acknowledge of the last entry clears all slots, `hit_count` and `overflow`, and returns the machine to IDLE.
- R7: A `train_start` pulse in any state clears slots, count and overflow and enters CAPTURE on the next edge.
- R8: `hit` has no effect in IDLE, in DRAIN, or in a cycle where `train_start` or `train_end` is high.
- R9: A `train_end` with no stored entries enters DRAIN, then returns to IDLE on the next edge without raising `rd_valid`.
- R10: `rd_ack` while `rd_valid` is 0 has no effect, and `rd_stamp` reads 0 whenever `rd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| train_start | input | 1 | One-clock pulse at the start of a bunch train |
| train_end | input | 1 | One-clock pulse at the end of a bunch train |
| hit | input | 1 | Discriminator output, level |
| bunch_num | input | STAMP_W (14) | Global bunch-crossing number |
| rd_ack | input | 1 | Readout accepts the presented entry |
| rd_valid | output | 1 | An entry is presented |
| rd_stamp | output | STAMP_W (14) | Crossing number of the presented entry |
| hit_count | output | clog2(DEPTH+1) | Entries captured this train |
| overflow | output | 1 | At least one hit was dropped this train |

## Verification
The assertions assume the following about the inputs:
- `train_start` and `train_end` are never high in the same cycle.
- `bunch_num` changes only between crossings and does not wrap within a train.
- `rd_ack` is raised only in the gap between trains.

The stimulus honours all three. Control pulses last exactly one clock. Crossing numbers within a train increase from below 3000. Acknowledges are issued only after `train_end`, apart from one deliberate acknowledge in IDLE that tests R10.

// File: rtl/pxb_pkg.sv
package pxb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_DRAIN   = 2'd2
    } pxb_state_e;
endpackage

// File: rtl/pxb_hit_qual.sv
// Turns a level hit into one "new crossing" event per crossing number.
module pxb_hit_qual #(
    parameter int STAMP_W = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               arm,
    input  logic               hit,
    input  logic [STAMP_W-1:0] bunch_num,
    output logic               take
);
    logic               seen_q;
    logic [STAMP_W-1:0] last_q;

    always_comb begin
        take = arm && hit && !(seen_q && (last_q == bunch_num));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (clear) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (take) begin
            seen_q <= 1'b1;
            last_q <= bunch_num;
        end
    end
endmodule

// File: rtl/pxb_slot_store.sv
// Few-deep stamp store: written in order, read in order, cleared as a whole.
module pxb_slot_store #(
    parameter int STAMP_W = 14,
    parameter int DEPTH   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       take,
    input  logic [STAMP_W-1:0]         bunch_num,
    input  logic                       pop,
    output logic [STAMP_W-1:0]         head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       ovf,
    output logic                       empty,
    output logic                       last_entry
);
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [STAMP_W-1:0] slot_q [DEPTH];
    logic [PTR_W-1:0]   rd_ptr_q;
    logic               full;

    always_comb begin
        full       = (count == CNT_W'(DEPTH));
        empty      = (count == '0);
        head       = slot_q[rd_ptr_q];
        last_entry = !empty && ((CNT_W'(rd_ptr_q) + CNT_W'(1)) == count);
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (clear) begin
                slot_q[g] <= '0;
            end else if (take && (count == CNT_W'(g))) begin
                slot_q[g] <= bunch_num;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count    <= '0;
            ovf      <= 1'b0;
            rd_ptr_q <= '0;
        end else if (clear) begin
            count    <= '0;
            ovf      <= 1'b0;
            rd_ptr_q <= '0;
        end else begin
            if (take && !full) count <= count + CNT_W'(1);
            if (take && full)  ovf   <= 1'b1;
            if (pop)           rd_ptr_q <= rd_ptr_q + PTR_W'(1);
        end
    end
endmodule

// File: rtl/pxb_ctrl.sv
// Train phase machine: IDLE -> CAPTURE -> DRAIN -> IDLE.
module pxb_ctrl
    import pxb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       train_start,
    input  logic       train_end,
    input  logic       pop_last,
    input  logic       empty,
    output pxb_state_e state
);
    pxb_state_e state_nx;

    always_comb begin
        state_nx = state;
        if (train_start) begin
            state_nx = ST_CAPTURE;
        end else begin
            unique case (state)
                ST_IDLE:    state_nx = ST_IDLE;
                ST_CAPTURE: if (train_end) state_nx = ST_DRAIN;
                ST_DRAIN:   if (pop_last || empty) state_nx = ST_IDLE;
                default:    state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end
endmodule

// File: rtl/pixel_tstamp_buf.sv
module pixel_tstamp_buf
    import pxb_pkg::*;
#(
    parameter int STAMP_W = 14,
    parameter int DEPTH   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       train_start,
    input  logic                       train_end,
    input  logic                       hit,
    input  logic [STAMP_W-1:0]         bunch_num,
    input  logic                       rd_ack,
    output logic                       rd_valid,
    output logic [STAMP_W-1:0]         rd_stamp,
    output logic [$clog2(DEPTH+1)-1:0] hit_count,
    output logic                       overflow
);
    localparam int CNT_W = $clog2(DEPTH+1);

    pxb_state_e         state;
    logic               arm, take, pop, pop_last, clear;
    logic               empty, last_entry, ovf;
    logic [STAMP_W-1:0] head;
    logic [CNT_W-1:0]   count;

    always_comb begin
        arm      = (state == ST_CAPTURE) && !train_start && !train_end;
        pop      = (state == ST_DRAIN) && rd_ack && !empty && !train_start;
        pop_last = pop && last_entry;
        clear    = train_start || pop_last;
    end

    pxb_hit_qual #(.STAMP_W(STAMP_W)) u_qual (
        .clk(clk), .rst_n(rst_n), .clear(clear), .arm(arm),
        .hit(hit), .bunch_num(bunch_num), .take(take)
    );

    pxb_slot_store #(.STAMP_W(STAMP_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .clear(clear), .take(take),
        .bunch_num(bunch_num), .pop(pop), .head(head), .count(count),
        .ovf(ovf), .empty(empty), .last_entry(last_entry)
    );

    pxb_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .train_start(train_start),
        .train_end(train_end), .pop_last(pop_last), .empty(empty),
        .state(state)
    );

    always_comb begin
        rd_valid  = (state == ST_DRAIN) && !empty;
        rd_stamp  = rd_valid ? head : '0;
        hit_count = count;
        overflow  = ovf;
    end
endmodule

// File: rtl/pixel_tstamp_buf_chk.sv
module pixel_tstamp_buf_chk
    import pxb_pkg::*;
#(
    parameter int STAMP_W = 14,
    parameter int DEPTH   = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       train_start,
    input logic                       train_end,
    input logic                       hit,
    input logic [STAMP_W-1:0]         bunch_num,
    input logic                       rd_ack,
    input logic                       rd_valid,
    input logic [$clog2(DEPTH+1)-1:0] hit_count,
    input logic                       overflow,
    input pxb_state_e                 state
);
    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hit_count <= DEPTH);

    assert_ovf_only_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> (hit_count == DEPTH));

    assert_valid_in_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (state == ST_DRAIN && hit_count != 0));

    assert_start_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        train_start |=> (hit_count == 0 && !overflow && !rd_valid && state == ST_CAPTURE));

    assert_drain_no_growth_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN && !train_start) |=> (hit_count <= $past(hit_count)));

    assert_idle_no_growth_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !train_start) |=> (hit_count == 0));

    assert_same_crossing_once_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CAPTURE && hit && !train_start && !train_end && $past(hit)
         && $past(state) == ST_CAPTURE && !$past(train_start)
         && bunch_num == $past(bunch_num)) |=> $stable(hit_count));

    assert_empty_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN && hit_count == 0 && !train_start) |=> (state == ST_IDLE));
endmodule

bind pixel_tstamp_buf pixel_tstamp_buf_chk #(.STAMP_W(STAMP_W), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .train_start(train_start), .train_end(train_end),
    .hit(hit), .bunch_num(bunch_num), .rd_ack(rd_ack), .rd_valid(rd_valid),
    .hit_count(hit_count), .overflow(overflow), .state(state)
);

// File: tb/pixel_tstamp_buf_bench.sv
module pixel_tstamp_buf_bench;
    localparam int STAMP_W = 14;
    localparam int DEPTH   = 4;
    localparam int CNT_W   = $clog2(DEPTH+1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic train_start = 1'b0, train_end = 1'b0, hit = 1'b0, rd_ack = 1'b0;
    logic [STAMP_W-1:0] bunch_num = '0;
    logic               rd_valid, overflow;
    logic [STAMP_W-1:0] rd_stamp;
    logic [CNT_W-1:0]   hit_count;

    always #5 clk = ~clk;

    pixel_tstamp_buf #(.STAMP_W(STAMP_W), .DEPTH(DEPTH)) u_pixel_tstamp_buf (
        .clk(clk), .rst_n(rst_n), .train_start(train_start), .train_end(train_end),
        .hit(hit), .bunch_num(bunch_num), .rd_ack(rd_ack), .rd_valid(rd_valid),
        .rd_stamp(rd_stamp), .hit_count(hit_count), .overflow(overflow)
    );

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    // scoreboard model
    logic [STAMP_W-1:0] exp_q [$];
    int  exp_cnt = 0;
    bit  exp_ovf = 1'b0, in_train = 1'b0, seen = 1'b0;
    logic [STAMP_W-1:0] last_bn = '0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic start_train();
        train_start = 1'b1;
        tick();
        train_start = 1'b0;
        exp_q.delete();
        exp_cnt = 0; exp_ovf = 1'b0; seen = 1'b0; in_train = 1'b1;
    endtask

    task automatic end_train();
        train_end = 1'b1;
        tick();
        train_end = 1'b0;
        in_train = 1'b0;
    endtask

    // driver: holds hit for 'hold' clocks at crossing bn and predicts the result
    task automatic drive_hit(input int bn, input int hold);
        bunch_num = STAMP_W'(bn);
        hit = 1'b1;
        for (int i = 0; i < hold; i++) begin
            if (in_train && !(seen && last_bn == STAMP_W'(bn))) begin
                seen = 1'b1; last_bn = STAMP_W'(bn);
                if (exp_cnt < DEPTH) begin
                    exp_q.push_back(STAMP_W'(bn));
                    exp_cnt++;
                end else begin
                    exp_ovf = 1'b1;
                end
            end
            tick();
        end
        hit = 1'b0;
    endtask

    // monitor: pops the scoreboard as the design presents entries
    task automatic drain(input string req);
        while (rd_valid) begin
            chk(exp_q.size() > 0, "R5", exp_q.size(), 1);
            if (exp_q.size() > 0)
                chk(rd_stamp == exp_q[0], req, rd_stamp, exp_q[0]);
            chk(hit_count == CNT_W'(exp_cnt), "R5", hit_count, exp_cnt);
            chk(overflow == exp_ovf, "R4", overflow, exp_ovf);
            if (exp_q.size() > 0) void'(exp_q.pop_front());
            rd_ack = 1'b1;
            tick();
            rd_ack = 1'b0;
        end
        chk(exp_q.size() == 0, "R5", exp_q.size(), 0);
        chk(hit_count == 0 && !overflow, "R6", hit_count, 0);
        chk(rd_stamp == 0, "R10", rd_stamp, 0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!rd_valid && rd_stamp == 0, "R1", rd_valid, 0);
        chk(hit_count == 0 && !overflow, "R1", hit_count, 0);
        rst_n = 1'b1;
        tick();

        // R8 hit in IDLE ignored; R10 stray ack ignored
        drive_hit(7, 2);
        chk(hit_count == 0, "R8", hit_count, 0);
        rd_ack = 1'b1; tick(); rd_ack = 1'b0;
        chk(!rd_valid && rd_stamp == 0, "R10", rd_valid, 0);

        // R2/R3: three crossings, first held for 3 clocks
        start_train();
        drive_hit(5, 3);
        chk(hit_count == 1, "R3", hit_count, 1);
        drive_hit(100, 1);
        drive_hit(2999, 2);
        chk(hit_count == 3, "R2", hit_count, 3);
        chk(!rd_valid, "R5", rd_valid, 0);
        end_train();
        // R8 hit during drain ignored
        drive_hit(2000, 2);
        chk(hit_count == 3, "R8", hit_count, 3);
        drain("R5");
        tick();
        chk(!rd_valid, "R6", rd_valid, 0);

        // R4 overflow: six crossings, one held across a crossing change
        start_train();
        drive_hit(10, 1);
        drive_hit(11, 1);
        drive_hit(12, 2);
        drive_hit(13, 1);
        chk(!overflow, "R4", overflow, 0);
        drive_hit(14, 1);
        drive_hit(15, 1);
        chk(hit_count == DEPTH && overflow, "R4", hit_count, DEPTH);
        end_train();
        drain("R4");

        // R7 train_start during drain clears
        start_train();
        drive_hit(40, 1);
        drive_hit(41, 1);
        end_train();
        chk(rd_valid && rd_stamp == 40, "R5", rd_stamp, 40);
        rd_ack = 1'b1; tick(); rd_ack = 1'b0;
        chk(rd_stamp == 41, "R5", rd_stamp, 41);
        start_train();
        chk(hit_count == 0 && !rd_valid && !overflow, "R7", hit_count, 0);
        drive_hit(41, 1);
        chk(hit_count == 1, "R7", hit_count, 1);
        end_train();
        drain("R7");

        // R9 empty train
        start_train();
        end_train();
        chk(!rd_valid, "R9", rd_valid, 0);
        tick();
        chk(!rd_valid && hit_count == 0, "R9", rd_valid, 0);
        drive_hit(77, 1);
        chk(hit_count == 0, "R9", hit_count, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule